// File: doc/BRIEF.md
# Refresh Request Generator with Missed-Refresh Backlog

This block turns a slow, free-running refresh clock into refresh requests for a DRAM sequencer that runs on the main clock. Every 64 rising edges of the refresh clock produce one request. The request crosses into the main clock domain through a toggle synchronizer, so each one is counted exactly once.

Requests that the sequencer cannot serve right away are kept in a saturating backlog. This happens, for example, while a long page-mode access keeps the row strobe low. As long as the backlog is non-zero the block holds its pending flag high, so the sequencer can issue row-only refreshes back to back until the backlog is empty. The sequencer reports each finished refresh with a one-cycle done pulse. The block also supplies the 10-bit row address for the next refresh and advances it by one after each refresh.

Top module: `rfsh_backlog`

## Requirements
- R1: One refresh tick is produced for every 64 rising edges of the refresh clock counted since reset; 63 edges produce no tick.
- R2: A tick is counted into the backlog at the third rising edge of the main clock after the refresh-clock edge that completes it. Each tick is counted exactly once.
- R3: The backlog saturates at 128: ticks that arrive while it holds 128 are dropped, so at most 128 done pulses are needed to empty it.
- R4: Each done pulse that does not coincide with a tick lowers a non-zero backlog by one. The pending output is 1 exactly when the backlog is non-zero.
- R5: The refresh row address is 1023 (all ones) after reset. Every done pulse raises it by one, wrapping from 1023 to 0.
- R6: A tick and a done pulse in the same main-clock cycle leave the backlog unchanged. The address still advances.
- R7: A done pulse while the backlog is zero leaves it at zero, with no underflow. The address still advances.
- R8: Reset clears the backlog and discards any partial count of refresh-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| rclk | input | 1 | Refresh clock, divided by 64 to make ticks |
| refresh_done | input | 1 | One-cycle pulse from the sequencer when a refresh finishes |
| refresh_pending | output | 1 | High while at least one refresh is owed |
| refresh_row | output | 10 | Row address for the next refresh |

## Verification
If the divider count is wrong, the pending flag rises one or more refresh-clock periods early or late. The bench detects this at the exact main-clock cycle where the flag should first go high. A wrong backlog value cannot be read directly, so it shows up as the wrong number of done pulses needed to clear pending. The bench therefore drains the backlog after every scenario, including saturation, a coincident tick and done, and a done pulse on an empty backlog. An address fault shows as a wrong row value on the cycle after the first affected done pulse, including the wrap from all ones to zero right after reset.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  // next backlog value given one tick and one done in the same cycle
  function automatic int unsigned backlog_step(int unsigned cur, int unsigned cap,
                                               logic tick, logic done);
    if (tick && !done) return (cur >= cap) ? cap : cur + 1;
    if (done && !tick) return (cur == 0) ? 0 : cur - 1;
    return cur;
  endfunction

  // row address increment, modulo 2**w
  function automatic int unsigned row_step(int unsigned cur, int unsigned w);
    return (cur + 1) % (32'd1 << w);
  endfunction
endpackage

// File: rtl/rfb_divider.sv
module rfb_divider #(
  parameter int unsigned DIV = 64
) (
  input  logic rclk,
  input  logic rst_n,
  output logic tick_toggle
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] edge_cnt;
  logic          wrap_now;

  assign wrap_now = (edge_cnt == CW'(DIV - 1));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt    <= '0;
      tick_toggle <= 1'b0;
    end else if (wrap_now) begin
      edge_cnt    <= '0;
      tick_toggle <= ~tick_toggle;
    end else begin
      edge_cnt    <= edge_cnt + 1'b1;
    end
  end

  assert_toggle_on_wrap_R1: assert property (@(posedge rclk) disable iff (!rst_n)
    wrap_now |=> (edge_cnt == '0) && (tick_toggle != $past(tick_toggle)));
  assert_hold_between_R1: assert property (@(posedge rclk) disable iff (!rst_n)
    !wrap_now |=> $stable(tick_toggle));
endmodule

// File: rtl/rfb_sync.sv
module rfb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_in,
  output logic tick_pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], toggle_in};
  end

  assign tick_pulse = chain[STAGES] ^ chain[STAGES-1];

  // a tick lasts exactly one cycle, so it is counted once (R2)
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse |=> !tick_pulse);
endmodule

// File: rtl/rfb_backlog.sv
module rfb_backlog #(
  parameter int unsigned CAP = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  output logic pending
);
  localparam int unsigned BW = $clog2(CAP + 1);

  logic [BW-1:0] owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= '0;
    else        owed <= BW'(rfb_pkg::backlog_step(32'(owed), CAP, tick, done));
  end

  assign pending = (owed != '0);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == BW'(CAP)) && tick && !done |=> owed == BW'(CAP));
  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !tick && (owed != '0) |=> owed == $past(owed) - 1'b1);
  assert_coincide_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && done |=> $stable(owed));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !tick && (owed == '0) |=> owed == '0);
endmodule

// File: rtl/rfb_row_counter.sv
module rfb_row_counter #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row <= '1;
    else if (step) row <= ADDR_W'(rfb_pkg::row_step(32'(row), ADDR_W));
  end

  assert_row_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> row == $past(row) + 1'b1);
  assert_row_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(row));
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int unsigned DIV         = 64,
  parameter int unsigned CAP         = 128,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rclk,
  input  logic              refresh_done,
  output logic              refresh_pending,
  output logic [ADDR_W-1:0] refresh_row
);
  logic tick_toggle;
  logic tick_main;

  rfb_divider #(.DIV(DIV)) u_div (
    .rclk(rclk), .rst_n(rst_n), .tick_toggle(tick_toggle));

  rfb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .toggle_in(tick_toggle), .tick_pulse(tick_main));

  rfb_backlog #(.CAP(CAP)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(tick_main), .done(refresh_done),
    .pending(refresh_pending));

  rfb_row_counter #(.ADDR_W(ADDR_W)) u_row (
    .clk(clk), .rst_n(rst_n), .step(refresh_done), .row(refresh_row));

  assert_tick_raises_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_main && !refresh_done |=> refresh_pending);
  assert_last_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_pending && !tick_main |=> !refresh_pending);
endmodule

// File: tb/rfsh_backlog_bench.sv
`timescale 1ns/1ps
module rfsh_backlog_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rclk = 1'b0;
  logic done = 1'b0;
  logic pending;
  logic [9:0] row;
  int checks = 0;
  int failures = 0;
  int exp_row = 1023;

  always #10 clk = ~clk;

  rfsh_backlog u_rfsh_backlog (
    .clk(clk), .rst_n(rst_n), .rclk(rclk), .refresh_done(done),
    .refresh_pending(pending), .refresh_row(row));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rpulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rclk = 1'b1; #5; rclk = 1'b0;
    end
  endtask

  task automatic give_ticks(input int n);
    rpulse(n * 64);
    repeat (4) @(negedge clk);
  endtask

  // issue done pulses until pending falls, return how many were needed
  task automatic drain(output int cnt);
    cnt = 0;
    while (pending && cnt < 300) begin
      done = 1'b1; @(negedge clk); done = 1'b0;
      cnt++;
      exp_row = (exp_row + 1) % 1024;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    exp_row = 1023;
  endtask

  initial begin
    int n;
    do_reset();
    check("R8 reset pending", pending, 0);
    check("R5 reset row", row, 1023);

    // R1: 63 edges give nothing
    rpulse(63);
    repeat (4) @(negedge clk);
    check("R1 63 edges no tick", pending, 0);
    // R2: 64th edge, exact latency
    rpulse(1);
    @(negedge clk); check("R2 cycle1 not yet", pending, 0);
    @(negedge clk); check("R2 cycle2 not yet", pending, 0);
    @(negedge clk); check("R2 cycle3 counted", pending, 1);
    // R5 wrap on first done
    drain(n);
    check("R4 single tick drain", n, 1);
    check("R5 wrap to zero", row, 0);
    // R7 done on empty backlog
    done = 1'b1; @(negedge clk); done = 1'b0; exp_row = (exp_row + 1) % 1024;
    check("R7 empty stays empty", pending, 0);
    check("R7 row advances", row, exp_row);

    // R4 multiple ticks
    give_ticks(5);
    check("R4 pending with backlog", pending, 1);
    drain(n);
    check("R4 five ticks drain", n, 5);
    check("R5 row after drain", row, exp_row);

    // R6 coincident tick and done
    give_ticks(2);
    rpulse(63);
    rpulse(1);
    @(negedge clk);
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0; exp_row = (exp_row + 1) % 1024;
    check("R6 row advanced", row, exp_row);
    drain(n);
    check("R6 backlog unchanged", n, 2);

    // R3 saturation
    give_ticks(131);
    drain(n);
    check("R3 saturate at 128", n, 128);
    check("R3 row after 128", row, exp_row);

    // R8 partial divider count discarded
    rpulse(40);
    do_reset();
    rpulse(24);
    repeat (4) @(negedge clk);
    check("R8 partial discarded", pending, 0);
    check("R8 row reset", row, 1023);
    rpulse(40);
    repeat (4) @(negedge clk);
    check("R8 tick after 64 fresh", pending, 1);
    drain(n);
    check("R8 one tick", n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule